// File: doc/BRIEF.md
# Packet-to-Bus Word Transaction Engine

This block sits behind a byte-stream deframer. Each request arrives as a packet of bytes marked with start and end flags. The first eight bytes form a request header. From it the block decides between four operations: a single word write, a run of word writes, a single word read, or a run of word reads. It then performs 32-bit accesses on a memory-mapped master port that supports wait-request and read-data-valid.

Every answer leaves as a packet on an output byte stream with ready/valid flow control. A read answer carries only the read words. A write answer, and the answer to any malformed request, is a four-byte status packet. Write data for a request is collected in a small word buffer first. A request whose data is cut short therefore never reaches the bus.

Top module: `pkt_bus_bridge`

## Requirements
- R1: A request starts with an input byte flagged as start. Bytes received while no request is open are ignored. Header byte 0 is the operation code and byte 1 is reserved. Bytes 2..3 hold the size in bytes, most significant byte first. Bytes 4..7 hold the 32-bit start address, most significant byte first. If the end flag arrives before the eighth header byte, the request is dropped with no reply.
- R2: Code 0x00 is a single write and code 0x04 a sequential write. Code 0x10 is a single read and code 0x14 a sequential read. A single operation is accepted only when its size is exactly 4.
- R3: Write words follow the header. Each word arrives least significant byte first. Each word produces one bus write, and a sequential write places word k at start address + 4k.
- R4: Once all bus writes of a request are accepted, the block sends a 4-byte reply in this order: code XOR 0x80, 0x00, size high byte, size low byte. The start flag is on the first byte and the end flag on the last.
- R5: A read request makes one bus read per word, at start address + 4k for word k. The reply holds only the read words, each least significant byte first. The start flag is on the very first byte and the end flag on the very last.
- R6: Some requests are rejected without any bus access: any other code (0x7F included), a size of 0, a size that is not a multiple of 4, a size above 4*MAX_WORDS, or a single operation with a size other than 4. Each rejected request gets a 4-byte reply of code XOR 0x80, 0x00, 0x00, 0x00.
- R7: A write request whose end flag arrives before all declared data bytes (or on the last header byte) causes no bus write and no reply.
- R8: Bytes after the declared header or data, up to the end flag, are ignored. A start-flagged byte inside an open request drops that request and begins a new header with this byte.
- R9: While wait-request is high, a pending bus read or write, together with its address and write data, stays unchanged. Read and write are never asserted together.
- R10: While output ready is low, a presented output byte and its flags stay unchanged.
- R11: After reset, input ready is high, output valid is low and no bus access is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte opens a packet |
| in_eop | input | 1 | Input byte closes a packet |
| in_ready | output | 1 | Block takes the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte opens a reply |
| out_eop | output | 1 | Output byte closes a reply |
| out_ready | input | 1 | Receiver takes the output byte |
| bus_addr | output | 32 | Bus byte address |
| bus_read | output | 1 | Bus read request |
| bus_write | output | 1 | Bus write request |
| bus_wdata | output | 32 | Bus write data |
| bus_waitreq | input | 1 | Bus stalls the current request |
| bus_rdvalid | input | 1 | Bus read data valid |
| bus_rdata | input | 32 | Bus read data |

## Verification
Several cases are hard to reach: a start flag that lands inside an open write, and a write packet that ends partway through its data words. Both must leave memory untouched and send nothing. The bench builds such packets on purpose and follows each one with a normal read, so the discarded bytes cannot leak into the next request. Random requests run with a memory model that raises wait-request at random and returns read data after a random delay, while output ready is toggled at random. Some requests also carry leading garbage or trailing filler.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  typedef enum logic [3:0] {
    S_HDR, S_DEC, S_WDAT, S_DRAIN, S_WLD, S_WBUS, S_RBUS, S_RWAIT, S_RSEND, S_RPLY
  } st_t;

  localparam logic [7:0] OP_WR1 = 8'h00;
  localparam logic [7:0] OP_WRN = 8'h04;
  localparam logic [7:0] OP_RD1 = 8'h10;
  localparam logic [7:0] OP_RDN = 8'h14;
endpackage

// File: rtl/pbb_hdr.sv
module pbb_hdr #(
  parameter int MAX_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        shift,
  input  logic        first,
  input  logic [7:0]  din,
  output logic [7:0]  code,
  output logic [15:0] size,
  output logic [31:0] addr,
  output logic        ok,
  output logic        rd,
  output logic        seq
);
  import pbb_pkg::*;
  localparam logic [16:0] MAXB = 17'(4 * MAX_WORDS);

  // reserved byte is shifted through and falls off the top
  logic [47:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      sr   <= '0;
    end else if (shift) begin
      if (first) code <= din;
      else       sr   <= {sr[39:0], din};
    end
  end

  assign size = sr[47:32];
  assign addr = sr[31:0];

  logic known;
  always_comb begin
    rd    = (code == OP_RD1) || (code == OP_RDN);
    seq   = (code == OP_WRN) || (code == OP_RDN);
    known = (code == OP_WR1) || (code == OP_WRN) || rd;
    ok    = known && (size[1:0] == 2'b00) && (size != 16'd0) &&
            ({1'b0, size} <= MAXB) && (seq || size == 16'd4);
  end
endmodule

// File: rtl/pbb_wbuf.sv
module pbb_wbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbb_tx_ser.sv
module pbb_tx_ser (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] word,
  input  logic        first,
  input  logic        last,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        busy
);
  logic [31:0] sr;
  logic [1:0]  idx;
  logic        vld, sopf, eopf;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; idx <= '0; vld <= 1'b0; sopf <= 1'b0; eopf <= 1'b0;
    end else if (load) begin
      sr <= word; idx <= '0; vld <= 1'b1; sopf <= first; eopf <= last;
    end else if (vld && out_ready) begin
      sr  <= {8'h00, sr[31:8]};
      idx <= idx + 2'd1;
      if (idx == 2'd3) vld <= 1'b0;
    end
  end

  assign out_valid = vld;
  assign out_data  = sr[7:0];
  assign out_sop   = vld && sopf && (idx == 2'd0);
  assign out_eop   = vld && eopf && (idx == 2'd3);
  assign busy      = vld;

  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_sop) && $stable(out_eop)));
endmodule

// File: rtl/pkt_bus_bridge.sv
module pkt_bus_bridge #(
  parameter int MAX_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop,
  input  logic        out_ready,
  output logic [31:0] bus_addr,
  output logic        bus_read,
  output logic        bus_write,
  output logic [31:0] bus_wdata,
  input  logic        bus_waitreq,
  input  logic        bus_rdvalid,
  input  logic [31:0] bus_rdata
);
  import pbb_pkg::*;
  localparam int CW = $clog2(MAX_WORDS + 1);
  localparam int AW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  st_t         st, after_drain;
  logic [3:0]  hcnt, hnext;
  logic        eop_seen, seq_q;
  logic [CW-1:0] widx, nwords;
  logic [1:0]  bcnt;
  logic [23:0] acc;
  logic [31:0] addr_q, rdat_q;
  logic [7:0]  code_q;
  logic [15:0] rsize_q;

  logic [7:0]  h_code;
  logic [15:0] h_size;
  logic [31:0] h_addr;
  logic        h_ok, h_rd, h_seq;

  logic accept, hdr_take, last_w, buf_we;
  logic tx_load, tx_first, tx_last, tx_busy;
  logic [31:0] tx_word, buf_rdata;

  assign in_ready = (st == S_HDR) || (st == S_WDAT) || (st == S_DRAIN);
  assign accept   = in_valid && in_ready;
  assign hdr_take = accept && ((st == S_HDR) ? (in_sop || hcnt != 4'd0) : in_sop);
  assign hnext    = in_sop ? 4'd1 : hcnt + 4'd1;
  assign last_w   = (widx == nwords - 1'b1);
  assign buf_we   = accept && (st == S_WDAT) && !in_sop && (bcnt == 2'd3);

  pbb_hdr #(.MAX_WORDS(MAX_WORDS)) u_hdr (
    .clk(clk), .rst(rst), .shift(hdr_take), .first(in_sop), .din(in_data),
    .code(h_code), .size(h_size), .addr(h_addr), .ok(h_ok), .rd(h_rd), .seq(h_seq)
  );

  pbb_wbuf #(.DW(32), .DEPTH(MAX_WORDS)) u_buf (
    .clk(clk), .we(buf_we), .waddr(widx[AW-1:0]), .wdata({in_data, acc}),
    .raddr(widx[AW-1:0]), .rdata(buf_rdata)
  );

  pbb_tx_ser u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .word(tx_word), .first(tx_first),
    .last(tx_last), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .busy(tx_busy)
  );

  always_comb begin
    tx_load  = 1'b0;
    tx_word  = rdat_q;
    tx_first = 1'b0;
    tx_last  = 1'b0;
    if (st == S_RSEND && !tx_busy) begin
      tx_load  = 1'b1;
      tx_first = (widx == '0);
      tx_last  = last_w;
    end else if (st == S_RPLY && !tx_busy) begin
      tx_load  = 1'b1;
      tx_word  = {rsize_q[7:0], rsize_q[15:8], 8'h00, code_q ^ 8'h80};
      tx_first = 1'b1;
      tx_last  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_HDR; after_drain <= S_HDR; hcnt <= '0; eop_seen <= 1'b0;
      seq_q <= 1'b0; widx <= '0; nwords <= '0; bcnt <= '0; acc <= '0;
      addr_q <= '0; rdat_q <= '0; code_q <= '0; rsize_q <= '0;
    end else begin
      case (st)
        S_HDR: if (hdr_take) begin
          if (hnext == 4'd8) begin
            st <= S_DEC; eop_seen <= in_eop; hcnt <= '0;
          end else begin
            hcnt <= in_eop ? 4'd0 : hnext;
          end
        end
        S_DEC: begin
          code_q <= h_code; addr_q <= h_addr; seq_q <= h_seq;
          nwords <= CW'(h_size >> 2); widx <= '0; bcnt <= '0;
          if (!h_ok) begin
            rsize_q <= '0;
            if (eop_seen) st <= S_RPLY;
            else begin after_drain <= S_RPLY; st <= S_DRAIN; end
          end else if (h_rd) begin
            if (eop_seen) st <= S_RBUS;
            else begin after_drain <= S_RBUS; st <= S_DRAIN; end
          end else begin
            rsize_q <= h_size;
            st <= eop_seen ? S_HDR : S_WDAT;
          end
        end
        S_WDAT: if (accept) begin
          if (in_sop) begin
            st <= S_HDR; hcnt <= in_eop ? 4'd0 : 4'd1;
          end else begin
            acc  <= {in_data, acc[23:8]};
            bcnt <= bcnt + 2'd1;
            if (bcnt == 2'd3) widx <= widx + 1'b1;
            if (bcnt == 2'd3 && last_w) begin
              widx <= '0;
              if (in_eop) st <= S_WLD;
              else begin after_drain <= S_WLD; st <= S_DRAIN; end
            end else if (in_eop) begin
              st <= S_HDR;
            end
          end
        end
        S_DRAIN: if (accept) begin
          if (in_sop) begin
            st <= S_HDR; hcnt <= in_eop ? 4'd0 : 4'd1;
          end else if (in_eop) begin
            st <= after_drain;
          end
        end
        S_WLD: st <= S_WBUS;
        S_WBUS: if (!bus_waitreq) begin
          widx <= widx + 1'b1;
          if (seq_q) addr_q <= addr_q + 32'd4;
          st <= last_w ? S_RPLY : S_WLD;
        end
        S_RBUS: if (!bus_waitreq) st <= S_RWAIT;
        S_RWAIT: if (bus_rdvalid) begin
          rdat_q <= bus_rdata; st <= S_RSEND;
        end
        S_RSEND: if (!tx_busy) begin
          widx <= widx + 1'b1;
          if (seq_q) addr_q <= addr_q + 32'd4;
          st <= last_w ? S_HDR : S_RBUS;
        end
        S_RPLY: if (!tx_busy) st <= S_HDR;
        default: st <= S_HDR;
      endcase
    end
  end

  assign bus_addr  = addr_q;
  assign bus_read  = (st == S_RBUS);
  assign bus_write = (st == S_WBUS);
  assign bus_wdata = buf_rdata;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_read && bus_write));
  a_r9_write_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_write && bus_waitreq) |=> (bus_write && $stable(bus_addr) && $stable(bus_wdata)));
  a_r9_read_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_read && bus_waitreq) |=> (bus_read && $stable(bus_addr)));
  a_r11_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_read && !bus_write && !out_valid && in_ready));
endmodule

// File: tb/pkt_bus_bridge_test.sv
module pkt_bus_bridge_test;
  localparam int MW = 16;
  typedef logic [9:0] item_t;  // {sop, eop, data}

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [7:0] out_data;
  logic out_ready = 1'b1;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_read, bus_write;
  logic bus_waitreq = 1'b0, bus_rdvalid = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2 clk = ~clk;

  pkt_bus_bridge #(.MAX_WORDS(MW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_ready(out_ready), .bus_addr(bus_addr),
    .bus_read(bus_read), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_waitreq(bus_waitreq), .bus_rdvalid(bus_rdvalid), .bus_rdata(bus_rdata)
  );

  logic [31:0] smem [256];
  logic [31:0] rmem [256];
  int wr_cnt = 0, rd_cnt = 0;
  logic pend = 1'b0;
  int plat = 0;
  logic [7:0] paddr = '0;
  int checks = 0, fails = 0, cyc = 0;
  item_t rxq[$];

  // memory model with random stalls and read latency
  always @(posedge clk) begin
    if (rst) begin
      bus_waitreq <= 1'b0; bus_rdvalid <= 1'b0; pend <= 1'b0;
    end else begin
      bus_rdvalid <= 1'b0;
      if (bus_write && !bus_waitreq) begin
        smem[bus_addr[9:2]] <= bus_wdata; wr_cnt <= wr_cnt + 1;
      end
      if (bus_read && !bus_waitreq) begin
        pend <= 1'b1; plat <= $urandom_range(0, 2); paddr <= bus_addr[9:2];
        rd_cnt <= rd_cnt + 1;
      end else if (pend) begin
        if (plat == 0) begin
          bus_rdvalid <= 1'b1; bus_rdata <= smem[paddr]; pend <= 1'b0;
        end else plat <= plat - 1;
      end
      bus_waitreq <= ($urandom_range(0, 3) == 0);
    end
  end

  always @(posedge clk) out_ready <= ($urandom_range(0, 3) != 0);

  always @(posedge clk)
    if (!rst && out_valid && out_ready) rxq.push_back({out_sop, out_eop, out_data});

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL all watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic void pb(ref item_t q[$], input logic [7:0] b, input bit s);
    q.push_back({s, 1'b0, b});
  endfunction

  function automatic void close_pkt(ref item_t q[$]);
    item_t t = q.pop_back();
    t[8] = 1'b1;
    q.push_back(t);
  endfunction

  function automatic void hdr(ref item_t q[$], input logic [7:0] code,
                              input logic [15:0] size, input logic [31:0] addr);
    pb(q, code, 1'b1); pb(q, 8'h00, 1'b0);
    pb(q, size[15:8], 1'b0); pb(q, size[7:0], 1'b0);
    pb(q, addr[31:24], 1'b0); pb(q, addr[23:16], 1'b0);
    pb(q, addr[15:8], 1'b0); pb(q, addr[7:0], 1'b0);
  endfunction

  function automatic void status_reply(ref item_t q[$], input logic [7:0] code,
                                       input logic [15:0] size);
    q.push_back({2'b10, code ^ 8'h80});
    q.push_back({2'b00, 8'h00});
    q.push_back({2'b00, size[15:8]});
    q.push_back({2'b01, size[7:0]});
  endfunction

  task automatic send(input item_t q[$]);
    foreach (q[i]) begin
      in_valid <= 1'b1; in_sop <= q[i][9]; in_eop <= q[i][8]; in_data <= q[i][7:0];
      @(posedge clk);
      while (!in_ready) @(posedge clk);
      if ($urandom_range(0, 4) == 0) begin
        in_valid <= 1'b0; @(posedge clk);
      end
    end
    in_valid <= 1'b0; in_sop <= 1'b0; in_eop <= 1'b0;
  endtask

  task automatic run(input item_t q[$], input item_t exq[$], input int ewr,
                     input int erd, input string rq);
    int w0, r0, t, bad;
    rxq.delete();
    w0 = wr_cnt; r0 = rd_cnt;
    send(q);
    t = 0;
    while (rxq.size() < exq.size() && t < 4000) begin @(posedge clk); t++; end
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(rxq.size() == exq.size(), rq, "reply length", rxq.size(), exq.size());
    if (rxq.size() == exq.size()) begin
      bad = -1;
      foreach (exq[i]) if (bad < 0 && rxq[i] !== exq[i]) bad = i;
      chk(bad < 0, rq, "reply byte {sop,eop,data}",
          (bad < 0) ? 0 : rxq[bad], (bad < 0) ? 0 : exq[bad]);
    end
    chk(wr_cnt - w0 == ewr, rq, "bus write count", wr_cnt - w0, ewr);
    chk(rd_cnt - r0 == erd, rq, "bus read count", rd_cnt - r0, erd);
    bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && smem[i] !== rmem[i]) bad = i;
    chk(bad < 0, rq, "memory contents", (bad < 0) ? 0 : smem[bad], (bad < 0) ? 0 : rmem[bad]);
  endtask

  // builds a valid request, updates the reference and the expected reply
  task automatic valid_req(input logic [7:0] code, input int words, input int idx,
                           input int junk, input int trail, input string rq);
    item_t q[$], e[$];
    logic [31:0] w;
    bit is_rd = code[4];
    for (int j = 0; j < junk; j++) pb(q, 8'($urandom), 1'b0);
    hdr(q, code, 16'(words * 4), 32'(idx * 4));
    if (is_rd) begin
      for (int k = 0; k < words; k++)
        for (int b = 0; b < 4; b++)
          e.push_back({(k == 0 && b == 0), (k == words - 1 && b == 3),
                       rmem[idx + k][8*b +: 8]});
    end else begin
      for (int k = 0; k < words; k++) begin
        w = $urandom;
        rmem[idx + k] = w;
        for (int b = 0; b < 4; b++) pb(q, w[8*b +: 8], 1'b0);
      end
      status_reply(e, code, 16'(words * 4));
    end
    for (int j = 0; j < trail; j++) pb(q, 8'($urandom), 1'b0);
    close_pkt(q);
    run(q, e, is_rd ? 0 : words, is_rd ? words : 0, rq);
  endtask

  task automatic bad_req(input logic [7:0] code, input logic [15:0] size,
                         input int extra, input string rq);
    item_t q[$], e[$];
    hdr(q, code, size, 32'h40);
    for (int j = 0; j < extra; j++) pb(q, 8'($urandom), 1'b0);
    close_pkt(q);
    status_reply(e, code, 16'h0000);
    run(q, e, 0, 0, rq);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      smem[i] = 32'h1000_0000 + i; rmem[i] = 32'h1000_0000 + i;
    end
    repeat (4) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R11", "in_ready after reset", in_ready, 1);
    chk(out_valid === 1'b0, "R11", "out_valid after reset", out_valid, 0);
    chk((bus_read | bus_write) === 1'b0, "R11", "bus idle after reset",
        {bus_read, bus_write}, 0);
    @(posedge clk);

    // R3 R4 single write, then R5 single read of same word
    valid_req(8'h00, 1, 10, 0, 0, "R3_R4 single write");
    valid_req(8'h10, 1, 10, 0, 0, "R5 single read");
    // R2 R3 R5 sequential operations at full buffer depth
    valid_req(8'h04, MW, 100, 0, 0, "R2_R3 seq write max");
    valid_req(8'h14, MW, 100, 0, 0, "R2_R5 seq read max");
    // R1 leading bytes before start are ignored; R8 trailing filler ignored
    valid_req(8'h10, 1, 3, 5, 0, "R1 junk before start");
    valid_req(8'h14, 3, 50, 0, 4, "R8 read trailing filler");
    valid_req(8'h04, 2, 60, 0, 3, "R8 write trailing filler");

    // R6 rejected requests
    bad_req(8'h7F, 16'd4, 0, "R6 no-transaction code");
    bad_req(8'h08, 16'd4, 4, "R6 unknown code");
    bad_req(8'h04, 16'd6, 6, "R6 size not multiple of 4");
    bad_req(8'h14, 16'd0, 0, "R6 size zero");
    bad_req(8'h00, 16'd8, 8, "R2_R6 single write size 8");
    bad_req(8'h14, 16'(4 * MW + 4), 0, "R6 size above limit");

    // R7 truncated write data, then header-only write
    begin
      item_t q[$], e[$];
      hdr(q, 8'h04, 16'd8, 32'd200 * 4);
      for (int j = 0; j < 5; j++) pb(q, 8'hEE, 1'b0);
      close_pkt(q);
      run(q, e, 0, 0, "R7 truncated write");
      q.delete();
      hdr(q, 8'h00, 16'd4, 32'd201 * 4);
      close_pkt(q);
      run(q, e, 0, 0, "R7 write without data");
    end
    // R1 header cut short
    begin
      item_t q[$], e[$];
      pb(q, 8'h10, 1'b1); pb(q, 8'h00, 1'b0); pb(q, 8'h00, 1'b0); pb(q, 8'h04, 1'b0);
      close_pkt(q);
      run(q, e, 0, 0, "R1 short header");
    end
    // R8 start inside header and inside write data restarts parsing
    begin
      item_t q[$], e[$];
      pb(q, 8'h00, 1'b1); pb(q, 8'h00, 1'b0); pb(q, 8'h00, 1'b0);
      hdr(q, 8'h10, 16'd4, 32'd7 * 4);
      close_pkt(q);
      for (int b = 0; b < 4; b++) e.push_back({(b == 0), (b == 3), rmem[7][8*b +: 8]});
      run(q, e, 0, 1, "R8 restart in header");
      q.delete(); e.delete();
      hdr(q, 8'h04, 16'd8, 32'd9 * 4);
      pb(q, 8'hAA, 1'b0); pb(q, 8'hBB, 1'b0); pb(q, 8'hCC, 1'b0);
      hdr(q, 8'h10, 16'd4, 32'd9 * 4);
      close_pkt(q);
      for (int b = 0; b < 4; b++) e.push_back({(b == 0), (b == 3), rmem[9][8*b +: 8]});
      run(q, e, 0, 1, "R7_R8 restart in write data");
    end

    // R9 R10 random traffic under random stalls and output back-pressure
    for (int n = 0; n < 60; n++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] code = (op == 0) ? 8'h00 : (op == 1) ? 8'h04 : (op == 2) ? 8'h10 : 8'h14;
      int words = code[2] ? $urandom_range(1, MW) : 1;
      int idx = $urandom_range(0, 256 - words);
      valid_req(code, words, idx, ($urandom_range(0, 3) == 0) ? 2 : 0,
                code[4] ? $urandom_range(0, 1) : 0, "R9_R10 random");
    end

    summary();
    $finish;
  end
endmodule